// File: doc/BRIEF.md
# Switch Host Access Port

This block is the host side of a time-slot switch. A processor sees it as a small memory-mapped peripheral: an 8-bit data bus, six address lines, an active-high strobe, a read/write line (high reads, low writes), an active-low select and an active-low acknowledge. One control register decides where a 32-entry channel window lands. The window can point at any of four streams in one of three stores. The data store holds bytes that the serial receive side has captured. The connection-low store holds, per output channel, either a source address or a message byte. The connection-high store holds per-channel message and drive-enable flags.

The strobe and select are brought into the switching clock domain through a synchroniser. A register access is acknowledged as soon as it is seen. A store access waits for a clock in which the serial datapath leaves the stores free. The acknowledge is held until the host releases the strobe or the select. A split mode sends reads to the data store and writes to the connection-low store. A global message bit forces every output channel into message mode with its driver enabled. The datapath side has a write port into the data store and read ports into all stores.

Top module: `swx_host_if`

## Requirements
- R1: After reset the acknowledge is high (inactive), the read-data enable is low, the control register reads 0x00, and every store location reads 0.
- R2: An access with address bit 5 low reaches the control register whatever address bits 4..0 hold. Control bit 7 is split mode, bit 6 is global message, bits 4..3 are the store select and bits 1..0 are the stream. Bits 5 and 2 always read back as 0.
- R3: A control register access is acknowledged on the third clock edge after the strobe and select become active.
- R4: A store access (address bit 5 high) is acknowledged on the first clock edge at which the datapath slot-free input is sampled high, counting from the fourth edge after the strobe becomes active. A write takes effect at that same edge.
- R5: The acknowledge stays low while the strobe and select are held, and goes high on the third edge after either is released. A held strobe starts no second access.
- R6: The read-data enable is high only while a read is being acknowledged. The data bus then carries the read value, and carries 0 otherwise.
- R7: With store select 10, address bits 4..0 and the stream field select one connection-low byte, at index stream*32+channel. Host writes and reads go to that byte, and the datapath reads it at the same index.
- R8: With store select 11, a write keeps only data bits 2 (message) and 0 (drive enable). A read returns those bits with every other bit 0.
- R9: With store select 01, reads return the byte the datapath wrote at that index. A host write is acknowledged but changes no store.
- R10: With store select 00, writes are acknowledged and change no store, and reads return 0.
- R11: With control bit 7 set, reads come from the data store and writes go to the connection-low store, whatever the store select holds.
- R12: While control bit 6 is set, the datapath sees message and drive enable as 1 for every location. When it clears, the stored flags apply again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Host select, active low |
| host_ds | input | 1 | Host strobe, active high |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 6 | Bit 5: window/control; bits 4..0: channel |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (0 when not enabled) |
| host_rdata_oe | output | 1 | Read data drive enable |
| host_ack_n | output | 1 | Acknowledge, active low |
| dp_slot_free | input | 1 | Datapath leaves the stores free this cycle |
| dp_dm_we | input | 1 | Datapath data-store write enable |
| dp_dm_waddr | input | 7 | Datapath data-store write index |
| dp_dm_wdata | input | 8 | Datapath data-store write byte |
| dp_dm_raddr | input | 7 | Datapath data-store read index |
| dp_dm_q | output | 8 | Datapath data-store read byte |
| dp_cm_raddr | input | 7 | Datapath connection-store read index |
| dp_cml_q | output | 8 | Connection-low byte at dp_cm_raddr |
| dp_cmh_msg | output | 1 | Effective message flag at dp_cm_raddr |
| dp_cmh_oe | output | 1 | Effective drive enable at dp_cm_raddr |

## Verification
The hardest case to reach is a store access that is stalled by a busy datapath. The acknowledge must not come early and must not be lost. The bench holds the slot-free input low before raising the strobe and releases it a known number of cycles later. It then checks the exact acknowledge edge against the edge where the slot first opened. A second hard case is a write that must not land anywhere: a data-store write, a write with reserved select, or a split-mode write. Each is checked by reading the neighbouring stores back through the host port and through the datapath read ports, which the bench compares with its own model on every clock.

// File: rtl/swx_pkg.sv
package swx_pkg;

    localparam int DW      = 8;
    localparam int NSTREAM = 4;
    localparam int NCHAN   = 32;
    localparam int SW      = $clog2(NSTREAM);
    localparam int CW      = $clog2(NCHAN);
    localparam int IW      = SW + CW;
    localparam int AW      = CW + 1;
    localparam int DEPTH   = NSTREAM * NCHAN;

    // store select codes; the control register field decodes these
    typedef enum logic [1:0] {
        MEM_NONE    = 2'b00,
        MEM_DATA    = 2'b01,
        MEM_CONN_LO = 2'b10,
        MEM_CONN_HI = 2'b11
    } mem_sel_e;

    // control register layout, bit 7 down to bit 0
    typedef struct packed {
        logic       split;
        logic       gmsg;
        logic       rsv5;
        mem_sel_e   msel;
        logic       rsv2;
        logic [1:0] strm;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } acc_state_e;

    function automatic ctrl_t clean_ctrl(input logic [DW-1:0] v);
        ctrl_t c;
        c      = ctrl_t'(v);
        c.rsv5 = 1'b0;
        c.rsv2 = 1'b0;
        return c;
    endfunction

    function automatic mem_sel_e pick_target(input ctrl_t c, input logic is_rd);
        if (c.split)
            return is_rd ? MEM_DATA : MEM_CONN_LO;
        return c.msel;
    endfunction

    function automatic logic [DW-1:0] pack_conn_hi(input logic msg, input logic oe);
        logic [DW-1:0] v;
        v    = '0;
        v[2] = msg;
        v[0] = oe;
        return v;
    endfunction

endpackage

// File: rtl/swx_sync.sv
module swx_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/swx_mem_bank.sv
module swx_mem_bank
    import swx_pkg::*;
#(
    parameter int NS = NSTREAM,
    parameter int NC = NCHAN,
    parameter int W  = DW,
    localparam int D  = NS * NC,
    localparam int XW = $clog2(D)
) (
    input  logic          clk,
    input  logic          rst,
    // datapath side
    input  logic          dp_dm_we,
    input  logic [XW-1:0] dp_dm_waddr,
    input  logic [W-1:0]  dp_dm_wdata,
    input  logic [XW-1:0] dp_dm_raddr,
    output logic [W-1:0]  dp_dm_q,
    input  logic [XW-1:0] dp_cm_raddr,
    output logic [W-1:0]  dp_cml_q,
    output logic          dp_chi_msg,
    output logic          dp_chi_oe,
    // host side
    input  logic [XW-1:0] h_idx,
    input  logic          h_we_clo,
    input  logic          h_we_chi,
    input  logic [W-1:0]  h_wdata,
    output logic [W-1:0]  h_dm_q,
    output logic [W-1:0]  h_clo_q,
    output logic          h_chi_msg,
    output logic          h_chi_oe
);
    logic [W-1:0] dm_mem  [D];
    logic [W-1:0] clo_mem [D];
    logic         chi_msg [D];
    logic         chi_oe  [D];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < D; i++) dm_mem[i] <= '0;
        end else if (dp_dm_we) begin
            dm_mem[dp_dm_waddr] <= dp_dm_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < D; i++) clo_mem[i] <= '0;
        end else if (h_we_clo) begin
            clo_mem[h_idx] <= h_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < D; i++) begin
                chi_msg[i] <= 1'b0;
                chi_oe[i]  <= 1'b0;
            end
        end else if (h_we_chi) begin
            chi_msg[h_idx] <= h_wdata[2];
            chi_oe[h_idx]  <= h_wdata[0];
        end
    end

    assign dp_dm_q    = dm_mem[dp_dm_raddr];
    assign dp_cml_q   = clo_mem[dp_cm_raddr];
    assign dp_chi_msg = chi_msg[dp_cm_raddr];
    assign dp_chi_oe  = chi_oe[dp_cm_raddr];

    assign h_dm_q    = dm_mem[h_idx];
    assign h_clo_q   = clo_mem[h_idx];
    assign h_chi_msg = chi_msg[h_idx];
    assign h_chi_oe  = chi_oe[h_idx];
endmodule

// File: rtl/swx_acc_ctrl.sv
module swx_acc_ctrl
    import swx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_s,
    input  logic [AW-1:0] addr,
    input  logic          rw,
    input  logic [DW-1:0] wdata,
    input  logic          slot_free,
    input  logic [DW-1:0] h_dm_q,
    input  logic [DW-1:0] h_clo_q,
    input  logic          h_chi_msg,
    input  logic          h_chi_oe,
    output ctrl_t         ctrl_q,
    output logic [IW-1:0] h_idx,
    output logic          h_we_clo,
    output logic          h_we_chi,
    output logic [DW-1:0] h_wdata,
    output logic          ack_n,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    output logic          acc_is_mem
);
    acc_state_e    st_q;
    logic          is_rd_q;
    logic          is_mem_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] wd_q;
    logic [DW-1:0] rdata_q;
    mem_sel_e      tgt;
    logic          do_mem;
    logic [DW-1:0] mem_rd;

    assign tgt    = pick_target(ctrl_q, is_rd_q);
    assign do_mem = (st_q == ST_WAIT) && slot_free;

    always_comb begin
        case (tgt)
            MEM_DATA:    mem_rd = h_dm_q;
            MEM_CONN_LO: mem_rd = h_clo_q;
            MEM_CONN_HI: mem_rd = pack_conn_hi(h_chi_msg, h_chi_oe);
            default:     mem_rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            is_rd_q  <= 1'b0;
            is_mem_q <= 1'b0;
            idx_q    <= '0;
            wd_q     <= '0;
            rdata_q  <= '0;
            ctrl_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (sel_s) begin
                        is_rd_q <= rw;
                        wd_q    <= wdata;
                        idx_q   <= {ctrl_q.strm, addr[CW-1:0]};
                        if (addr[CW]) begin
                            is_mem_q <= 1'b1;
                            st_q     <= ST_WAIT;
                        end else begin
                            is_mem_q <= 1'b0;
                            st_q     <= ST_ACK;
                            if (rw) rdata_q <= ctrl_q;
                            else    ctrl_q  <= clean_ctrl(wdata);
                        end
                    end
                end
                ST_WAIT: begin
                    if (slot_free) begin
                        if (is_rd_q) rdata_q <= mem_rd;
                        st_q <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (!sel_s) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign h_idx      = idx_q;
    assign h_wdata    = wd_q;
    assign h_we_clo   = do_mem && !is_rd_q && (tgt == MEM_CONN_LO);
    assign h_we_chi   = do_mem && !is_rd_q && (tgt == MEM_CONN_HI);
    assign ack_n      = (st_q != ST_ACK);
    assign rdata_oe   = (st_q == ST_ACK) && is_rd_q;
    assign rdata      = rdata_oe ? rdata_q : '0;
    assign acc_is_mem = is_mem_q;
endmodule

// File: rtl/swx_host_if.sv
module swx_host_if
    import swx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_cs_n,
    input  logic          host_ds,
    input  logic          host_rw,
    input  logic [5:0]    host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          host_rdata_oe,
    output logic          host_ack_n,
    input  logic          dp_slot_free,
    input  logic          dp_dm_we,
    input  logic [6:0]    dp_dm_waddr,
    input  logic [7:0]    dp_dm_wdata,
    input  logic [6:0]    dp_dm_raddr,
    output logic [7:0]    dp_dm_q,
    input  logic [6:0]    dp_cm_raddr,
    output logic [7:0]    dp_cml_q,
    output logic          dp_cmh_msg,
    output logic          dp_cmh_oe
);
    logic [1:0]    strb_s;
    logic          sel_s;
    ctrl_t         ctrl_q;
    logic          gmsg_w;
    logic          acc_is_mem;
    logic [IW-1:0] h_idx;
    logic          h_we_clo;
    logic          h_we_chi;
    logic [DW-1:0] h_wdata;
    logic [DW-1:0] h_dm_q;
    logic [DW-1:0] h_clo_q;
    logic          h_chi_msg;
    logic          h_chi_oe;
    logic          chi_msg_raw;
    logic          chi_oe_raw;

    // bit 1: select (inactive high), bit 0: strobe
    swx_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({host_cs_n, host_ds}),
        .q   (strb_s)
    );

    assign sel_s = strb_s[0] && !strb_s[1];

    swx_acc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sel_s      (sel_s),
        .addr       (host_addr),
        .rw         (host_rw),
        .wdata      (host_wdata),
        .slot_free  (dp_slot_free),
        .h_dm_q     (h_dm_q),
        .h_clo_q    (h_clo_q),
        .h_chi_msg  (h_chi_msg),
        .h_chi_oe   (h_chi_oe),
        .ctrl_q     (ctrl_q),
        .h_idx      (h_idx),
        .h_we_clo   (h_we_clo),
        .h_we_chi   (h_we_chi),
        .h_wdata    (h_wdata),
        .ack_n      (host_ack_n),
        .rdata      (host_rdata),
        .rdata_oe   (host_rdata_oe),
        .acc_is_mem (acc_is_mem)
    );

    swx_mem_bank #(.NS(NSTREAM), .NC(NCHAN), .W(DW)) u_mem (
        .clk         (clk),
        .rst         (rst),
        .dp_dm_we    (dp_dm_we),
        .dp_dm_waddr (dp_dm_waddr),
        .dp_dm_wdata (dp_dm_wdata),
        .dp_dm_raddr (dp_dm_raddr),
        .dp_dm_q     (dp_dm_q),
        .dp_cm_raddr (dp_cm_raddr),
        .dp_cml_q    (dp_cml_q),
        .dp_chi_msg  (chi_msg_raw),
        .dp_chi_oe   (chi_oe_raw),
        .h_idx       (h_idx),
        .h_we_clo    (h_we_clo),
        .h_we_chi    (h_we_chi),
        .h_wdata     (h_wdata),
        .h_dm_q      (h_dm_q),
        .h_clo_q     (h_clo_q),
        .h_chi_msg   (h_chi_msg),
        .h_chi_oe    (h_chi_oe)
    );

    assign gmsg_w     = ctrl_q.gmsg;
    assign dp_cmh_msg = chi_msg_raw || gmsg_w;
    assign dp_cmh_oe  = chi_oe_raw  || gmsg_w;
endmodule

// File: rtl/swx_host_if_chk.sv
module swx_host_if_chk (
    input logic clk,
    input logic rst,
    input logic host_ack_n,
    input logic host_rdata_oe,
    input logic sel_s,
    input logic acc_is_mem,
    input logic dp_slot_free,
    input logic gmsg,
    input logic dp_cmh_msg,
    input logic dp_cmh_oe
);
    // R1: acknowledge inactive on the first edge after reset
    p_rst_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> host_ack_n);

    // R3: an acknowledge only starts while the synchronised strobe is active
    p_ack_needs_sel_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(host_ack_n) |-> sel_s);

    // R4: a store access is acknowledged only after a free slot
    p_mem_slot_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(host_ack_n) && acc_is_mem) |-> $past(dp_slot_free));

    // R5: acknowledge held while the strobe stays active
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!host_ack_n && sel_s) |=> !host_ack_n);

    // R6: read data enabled only under acknowledge
    p_oe_in_ack_r6: assert property (@(posedge clk) disable iff (rst)
        host_rdata_oe |-> !host_ack_n);

    // R12: global message forces message and drive for the datapath
    p_gmsg_force_r12: assert property (@(posedge clk) disable iff (rst)
        gmsg |-> (dp_cmh_msg && dp_cmh_oe));
endmodule

bind swx_host_if swx_host_if_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .host_ack_n    (host_ack_n),
    .host_rdata_oe (host_rdata_oe),
    .sel_s         (sel_s),
    .acc_is_mem    (acc_is_mem),
    .dp_slot_free  (dp_slot_free),
    .gmsg          (gmsg_w),
    .dp_cmh_msg    (dp_cmh_msg),
    .dp_cmh_oe     (dp_cmh_oe)
);

// File: tb/swx_host_if_tb_top.sv
module swx_host_if_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_cs_n = 1'b1;
    logic       host_ds = 1'b0;
    logic       host_rw = 1'b1;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rdata_oe;
    logic       host_ack_n;
    logic       dp_slot_free = 1'b1;
    logic       dp_dm_we = 1'b0;
    logic [6:0] dp_dm_waddr = '0;
    logic [7:0] dp_dm_wdata = '0;
    logic [6:0] dp_dm_raddr = '0;
    logic [7:0] dp_dm_q;
    logic [6:0] dp_cm_raddr = '0;
    logic [7:0] dp_cml_q;
    logic       dp_cmh_msg;
    logic       dp_cmh_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // behavioural model
    logic [7:0] m_ctrl;
    logic [7:0] m_dm  [128];
    logic [7:0] m_cml [128];
    logic       m_msg [128];
    logic       m_oe  [128];

    always #2 clk = ~clk;

    swx_host_if dut_i (
        .clk(clk), .rst(rst),
        .host_cs_n(host_cs_n), .host_ds(host_ds), .host_rw(host_rw),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe), .host_ack_n(host_ack_n),
        .dp_slot_free(dp_slot_free),
        .dp_dm_we(dp_dm_we), .dp_dm_waddr(dp_dm_waddr), .dp_dm_wdata(dp_dm_wdata),
        .dp_dm_raddr(dp_dm_raddr), .dp_dm_q(dp_dm_q),
        .dp_cm_raddr(dp_cm_raddr), .dp_cml_q(dp_cml_q),
        .dp_cmh_msg(dp_cmh_msg), .dp_cmh_oe(dp_cmh_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic void model_write(input logic [5:0] a, input logic [7:0] d);
        int idx;
        idx = m_ctrl[1:0] * 32 + a[4:0];
        if (!a[5]) begin
            m_ctrl = d & 8'hDB;
        end else if (m_ctrl[7]) begin
            m_cml[idx] = d;
        end else if (m_ctrl[4:3] == 2'b10) begin
            m_cml[idx] = d;
        end else if (m_ctrl[4:3] == 2'b11) begin
            m_msg[idx] = d[2];
            m_oe[idx]  = d[0];
        end
    endfunction

    // per-clock comparison of the datapath read ports with the model
    always @(negedge clk) begin
        #1;
        cycles++;
        if (!rst && !done) begin
            chk(dp_cml_q == m_cml[dp_cm_raddr], "R7 dp conn-low", dp_cml_q, m_cml[dp_cm_raddr]);
            chk(dp_cmh_msg == (m_msg[dp_cm_raddr] | m_ctrl[6]), "R12 dp msg",
                dp_cmh_msg, m_msg[dp_cm_raddr] | m_ctrl[6]);
            chk(dp_cmh_oe == (m_oe[dp_cm_raddr] | m_ctrl[6]), "R12 dp oe",
                dp_cmh_oe, m_oe[dp_cm_raddr] | m_ctrl[6]);
            chk(dp_dm_q == m_dm[dp_dm_raddr], "R9 dp data", dp_dm_q, m_dm[dp_dm_raddr]);
            if (host_ack_n) chk(!host_rdata_oe, "R6 oe idle", host_rdata_oe, 0);
            dp_cm_raddr = dp_cm_raddr + 7'd37;
            dp_dm_raddr = dp_dm_raddr + 7'd11;
        end
    end

    // watchdog
    initial begin
        wait (cycles > 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic dm_write(input int idx, input logic [7:0] d);
        @(negedge clk);
        dp_dm_we = 1'b1; dp_dm_waddr = idx[6:0]; dp_dm_wdata = d;
        @(negedge clk);
        m_dm[idx] = d;
        dp_dm_we = 1'b0;
    endtask

    // one host access with cycle-exact acknowledge and release checks
    task automatic acc(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                       input int exp_lat, input int hold, input int slot_at,
                       input logic [7:0] exp_rd, input string req);
        int lat;
        @(negedge clk);
        if (slot_at > 0) dp_slot_free = 1'b0;
        host_rw = rd; host_addr = a; host_wdata = wd;
        host_cs_n = 1'b0; host_ds = 1'b1;
        lat = 0;
        while (host_ack_n && lat < 64) begin
            @(negedge clk);
            lat++;
            if (slot_at > 0 && lat == slot_at) dp_slot_free = 1'b1;
        end
        dp_slot_free = 1'b1;
        chk(lat == exp_lat, {req, " ack latency"}, lat, exp_lat);
        if (!rd) model_write(a, wd);
        if (rd) begin
            chk(host_rdata_oe == 1'b1, "R6 oe on read", host_rdata_oe, 1);
            chk(host_rdata == exp_rd, {req, " read data"}, host_rdata, exp_rd);
        end else begin
            chk(host_rdata_oe == 1'b0, "R6 oe off on write", host_rdata_oe, 0);
            chk(host_rdata == 8'h00, "R6 bus zero on write", host_rdata, 0);
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(host_ack_n == 1'b0, "R5 ack held", host_ack_n, 0);
        end
        host_ds = 1'b0; host_cs_n = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk(host_ack_n == (k == 3), "R5 ack release", host_ack_n, (k == 3));
        end
    endtask

    initial begin
        m_ctrl = '0;
        for (int i = 0; i < 128; i++) begin
            m_dm[i] = '0; m_cml[i] = '0; m_msg[i] = 1'b0; m_oe[i] = 1'b0;
        end
        repeat (5) @(negedge clk);
        chk(host_ack_n == 1'b1, "R1 ack after reset", host_ack_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(host_rdata_oe == 1'b0, "R1 oe after reset", host_rdata_oe, 0);

        // R1 R3: control register reads 0 after reset, fast acknowledge
        acc(1'b1, 6'h00, 8'h00, 3, 0, 0, 8'h00, "R1 R3 ctrl read");
        // R2: reserved bits dropped; other address bits ignored
        acc(1'b0, 6'h15, 8'h36, 3, 0, 0, 8'h00, "R2 ctrl write");
        acc(1'b1, 6'h0A, 8'h00, 3, 0, 0, 8'h12, "R2 ctrl readback");

        // R7: connection-low stream 2 channel 5
        acc(1'b0, 6'h25, 8'hA7, 4, 0, 0, 8'h00, "R4 R7 conn-low write");
        acc(1'b1, 6'h25, 8'h00, 4, 0, 0, 8'hA7, "R7 conn-low read");
        acc(1'b1, 6'h26, 8'h00, 4, 0, 0, 8'h00, "R7 neighbour untouched");

        // R8: connection-high stream 1
        acc(1'b0, 6'h19, 8'h19, 3, 0, 0, 8'h00, "R2 select conn-high");
        acc(1'b0, 6'h29, 8'hFF, 4, 0, 0, 8'h00, "R8 conn-high write");
        acc(1'b1, 6'h29, 8'h00, 4, 0, 0, 8'h05, "R8 conn-high read");
        acc(1'b0, 6'h2A, 8'hFA, 4, 0, 0, 8'h00, "R8 conn-high write2");
        acc(1'b1, 6'h2A, 8'h00, 4, 0, 0, 8'h00, "R8 conn-high read2");

        // R9: data store, stream 3 channel 7 (index 103)
        dm_write(103, 8'h5C);
        acc(1'b0, 6'h0B, 8'h0B, 3, 0, 0, 8'h00, "R2 select data");
        acc(1'b1, 6'h27, 8'h00, 4, 0, 0, 8'h5C, "R9 data read");
        acc(1'b0, 6'h27, 8'h11, 4, 0, 0, 8'h00, "R9 data write acked");
        acc(1'b1, 6'h27, 8'h00, 4, 0, 0, 8'h5C, "R9 data write ignored");

        // R10: reserved select
        acc(1'b0, 6'h02, 8'h02, 3, 0, 0, 8'h00, "R2 select none");
        acc(1'b0, 6'h23, 8'h77, 4, 0, 0, 8'h00, "R10 write acked");
        acc(1'b1, 6'h23, 8'h00, 4, 0, 0, 8'h00, "R10 read zero");
        acc(1'b0, 6'h12, 8'h12, 3, 0, 0, 8'h00, "R2 select conn-low s2");
        acc(1'b1, 6'h23, 8'h00, 4, 0, 0, 8'h00, "R10 conn-low unchanged");

        // R11: split mode with select on conn-high, stream 3
        acc(1'b0, 6'h00, 8'h9B, 3, 0, 0, 8'h00, "R11 split on");
        acc(1'b0, 6'h27, 8'h3C, 4, 0, 0, 8'h00, "R11 split write");
        acc(1'b1, 6'h27, 8'h00, 4, 0, 0, 8'h5C, "R11 split read data");
        acc(1'b0, 6'h00, 8'h1B, 3, 0, 0, 8'h00, "R11 split off");
        acc(1'b1, 6'h27, 8'h00, 4, 0, 0, 8'h00, "R11 conn-high untouched");
        acc(1'b0, 6'h00, 8'h13, 3, 0, 0, 8'h00, "R11 select conn-low s3");
        acc(1'b1, 6'h27, 8'h00, 4, 0, 0, 8'h3C, "R11 conn-low got write");

        // R4: stalled by a busy datapath, slot opens for the edge after lat 7
        acc(1'b1, 6'h27, 8'h00, 8, 0, 7, 8'h3C, "R4 stalled read");
        acc(1'b0, 6'h28, 8'h44, 5, 0, 4, 8'h00, "R4 stalled write");
        acc(1'b1, 6'h28, 8'h00, 4, 0, 0, 8'h44, "R4 stalled write landed");

        // R5: long hold, single write only
        acc(1'b0, 6'h2C, 8'h66, 4, 10, 0, 8'h00, "R5 held write");
        acc(1'b1, 6'h2C, 8'h00, 4, 0, 0, 8'h66, "R5 held write data");

        // R12: global message on, then off
        acc(1'b0, 6'h00, 8'h53, 3, 0, 0, 8'h00, "R12 gmsg on");
        repeat (40) @(negedge clk);
        #1;
        chk(dp_cmh_msg && dp_cmh_oe, "R12 forced flags", {dp_cmh_msg, dp_cmh_oe}, 3);
        acc(1'b1, 6'h00, 8'h00, 3, 0, 0, 8'h53, "R12 ctrl read");
        acc(1'b0, 6'h00, 8'h13, 3, 0, 0, 8'h00, "R12 gmsg off");
        repeat (140) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule